// File: doc/BRIEF.md
# Decoded Micro-op Window Cache

This block keeps already-decoded micro-ops so that fetch can skip the legacy decoders for hot code. Code space is cut into aligned 32-byte windows. The window of an address is that address with bits 4..0 cleared. Each cached window owns up to three ways, and each way holds up to six micro-op slots. A fill stream delivers decoded micro-ops one per cycle. Each carries its instruction address, a 16-bit opaque payload, a 4-bit instruction length, a flag for an unconditional jump and a flag that marks the last micro-op of the window being filled. The fill logic packs these micro-ops into ways. A way is closed when all six slots are used or right after a jump. A fill that would need a fourth way makes the window uncacheable.

A lookup takes a fetch address. One cycle later it answers with a single-cycle hit or miss pulse. On a hit, the ways of the window are then streamed in the order they were allocated, one way per cycle. A miss means the legacy path serves the fetch. The block also reports the fetch width of the current source: 32 bytes per clock from the cache, 16 from the legacy path. A switch pulse marks each change of source between consecutive lookups.

The fill controller has three states. FL_IDLE waits for the first micro-op of a fill. FL_PACK writes the micro-ops that follow. FL_DROP throws away the rest of a rejected or overflowed fill. The transitions are:
- FL_IDLE to FL_PACK on a start that is not last.
- FL_IDLE to FL_DROP when the window is marked uncacheable.
- FL_PACK to FL_IDLE on the last micro-op, whether it commits or overflows.
- FL_PACK to FL_DROP on an overflow that is not last.
- FL_DROP to FL_IDLE on the last micro-op.

The lookup controller has two states. LK_IDLE accepts lookups. LK_STREAM presents one way per cycle. It enters LK_STREAM on a hit and returns to LK_IDLE after the final way. A flush returns both controllers to idle.

Top module: `uop_window_cache`

## Requirements
- R1: After reset, hit_o, miss_o, switch_o and out_way_valid are 0, lk_ready is 1, fetch_bytes is 16, and every lookup misses.
- R2: A window is selected by address bits 31..5: bits 8..5 pick one of 16 sets and bits 31..9 are the tag. Bits 4..0 of a lookup address have no effect on the result.
- R3: A way holds at most 6 micro-ops. The 7th micro-op of a fill without jumps opens the next way.
- R4: A micro-op with fill_jump=1 closes its way, so the next micro-op of the same fill starts a new way even if slots remain.
- R5: A fill needing at most 3 ways is cached. A fill that would need a 4th way discards its ways and marks the window uncacheable. Lookups to that window then miss, and later fills to it are dropped.
- R6: A one-cycle flush invalidates every window and clears every uncacheable mark, and the window history used by switch_o.
- R7: A hit is reported one cycle after the lookup is accepted. In that same cycle way 0 appears, and each following cycle shows the next way in allocation order. out_slot_vld has its low N bits set for a way of N micro-ops. out_last_way marks the final way, and lk_ready is 0 while ways stream. Slot s of a way carries payload bits [16s+15:16s] and length bits [4s+3:4s], in fill order.
- R8: A lookup to an empty set, or to a set whose tag differs, gives a one-cycle miss_o pulse one cycle after acceptance, with no ways streamed.
- R9: A fill to a set whose stored tag differs evicts the previous window entirely.
- R10: switch_o pulses together with a hit or miss response when that response differs in kind from the previous response. It does not pulse on the first response after reset or flush.
- R11: fetch_bytes is 32 after a hit response and 16 after a miss response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all windows and uncacheable marks |
| fill_valid | input | 1 | A decoded micro-op is present on the fill inputs |
| fill_addr | input | 32 | Instruction address of the micro-op |
| fill_payload | input | 16 | Opaque micro-op payload |
| fill_len | input | 4 | Instruction byte length |
| fill_jump | input | 1 | Micro-op is an unconditional branch |
| fill_last | input | 1 | Last micro-op of this window's fill |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address of the lookup |
| lk_ready | output | 1 | Lookup accepted when high |
| hit_o | output | 1 | One-cycle hit response |
| miss_o | output | 1 | One-cycle miss (legacy path) response |
| switch_o | output | 1 | One-cycle pulse on change of fetch source |
| fetch_bytes | output | 6 | Bytes per clock of the current source (32 or 16) |
| out_way_valid | output | 1 | A cached way is on the output bus |
| out_last_way | output | 1 | The way shown is the final one of the window |
| out_slot_vld | output | 6 | Per-slot valid of the way shown |
| out_payload | output | 96 | Payloads of the six slots |
| out_len | output | 24 | Lengths of the six slots |

## Verification
The bench fills windows at the packing edges:
- exactly six micro-ops and a seventh that spills into a new way;
- a jump in mid-way;
- three jump-terminated ways;
- eighteen micro-ops, which fit;
- nineteen, or four jumps, which do not.

A design that miscounts slots or ignores a jump would show the wrong per-way valid patterns. One that allows a fourth way, or keeps partial ways after an overflow, would report a hit where a miss is due.

The bench also refills an uncacheable window, looks up a different tag in the same set, and evicts one window with another. A design that lost the uncacheable mark or compared only the set index would then return stale micro-ops.

Lookup sequences that alternate hits and misses, including across a flush, catch switch pulses that are missing, repeated, or raised on the first response.

// File: rtl/uwc_pkg.sv
package uwc_pkg;
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_CHUNK_B = 5;
    localparam int DEF_SETS    = 16;
    localparam int DEF_WAYS    = 3;
    localparam int DEF_SLOTS   = 6;
    localparam int DEF_PAY_W   = 16;
    localparam int DEF_LEN_W   = 4;

    typedef enum logic [1:0] {FL_IDLE, FL_PACK, FL_DROP} fill_st_e;
    typedef enum logic       {LK_IDLE, LK_STREAM}        look_st_e;
endpackage

// File: rtl/uwc_fill_ctl.sv
module uwc_fill_ctl
    import uwc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CHUNK_B = DEF_CHUNK_B,
    parameter int SETS    = DEF_SETS,
    parameter int WAYS    = DEF_WAYS,
    parameter int SLOTS   = DEF_SLOTS,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - CHUNK_B - SET_W,
    localparam int WAY_W  = $clog2(WAYS + 1),
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_jump,
    input  logic              fill_last,
    input  logic              probe_unc_hit,
    output logic [TAG_W-1:0]  f_tag,
    output logic              start_en,
    output logic              wr_en,
    output logic [SET_W-1:0]  wr_set,
    output logic [WAY_W-1:0]  wr_way,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              commit_en,
    output logic [WAY_W-1:0]  commit_nw,
    output logic              ovf_en
);
    fill_st_e          state_q, state_d;
    logic [SET_W-1:0]  cur_set_q;
    logic [WAY_W-1:0]  cur_way_q, way_d;
    logic [SLOT_W-1:0] cur_cnt_q, cnt_d;
    logic              closed_q, closed_d;
    logic              go, need_new, last_way;
    logic [SET_W-1:0]  f_set;

    assign f_set    = fill_addr[CHUNK_B +: SET_W];
    assign f_tag    = fill_addr[ADDR_W-1 -: TAG_W];
    assign go       = fill_valid && !flush;
    assign need_new = closed_q || (cur_cnt_q == SLOT_W'(SLOTS));
    assign last_way = (cur_way_q == WAY_W'(WAYS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= FL_IDLE;
            cur_set_q <= '0;
            cur_way_q <= '0;
            cur_cnt_q <= '0;
            closed_q  <= 1'b0;
        end else if (flush) begin
            state_q   <= FL_IDLE;
        end else begin
            state_q   <= state_d;
            cur_way_q <= way_d;
            cur_cnt_q <= cnt_d;
            closed_q  <= closed_d;
            if (start_en) cur_set_q <= f_set;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        way_d     = cur_way_q;
        cnt_d     = cur_cnt_q;
        closed_d  = closed_q;
        start_en  = 1'b0;
        wr_en     = 1'b0;
        wr_set    = f_set;
        wr_way    = '0;
        wr_slot   = '0;
        commit_en = 1'b0;
        commit_nw = '0;
        ovf_en    = 1'b0;
        unique case (state_q)
            FL_IDLE: begin
                if (go) begin
                    if (probe_unc_hit) begin
                        if (!fill_last) state_d = FL_DROP;
                    end else begin
                        start_en = 1'b1;
                        wr_en    = 1'b1;
                        way_d    = '0;
                        cnt_d    = SLOT_W'(1);
                        closed_d = fill_jump;
                        if (fill_last) begin
                            commit_en = 1'b1;
                            commit_nw = WAY_W'(1);
                        end else begin
                            state_d = FL_PACK;
                        end
                    end
                end
            end
            FL_PACK: begin
                wr_set = cur_set_q;
                if (go) begin
                    if (need_new && last_way) begin
                        ovf_en  = 1'b1;
                        state_d = fill_last ? FL_IDLE : FL_DROP;
                    end else begin
                        wr_en = 1'b1;
                        if (need_new) begin
                            way_d   = cur_way_q + 1'b1;
                            wr_slot = '0;
                        end else begin
                            wr_slot = cur_cnt_q;
                        end
                        wr_way   = way_d;
                        cnt_d    = wr_slot + 1'b1;
                        closed_d = fill_jump;
                        if (fill_last) begin
                            commit_en = 1'b1;
                            commit_nw = way_d + 1'b1;
                            state_d   = FL_IDLE;
                        end
                    end
                end
            end
            FL_DROP: begin
                if (go && fill_last) state_d = FL_IDLE;
            end
            default: state_d = FL_IDLE;
        endcase
    end

    // R5
    no_commit_after_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_en |-> !commit_en && !wr_en);
endmodule

// File: rtl/uwc_store.sv
module uwc_store
    import uwc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CHUNK_B = DEF_CHUNK_B,
    parameter int SETS    = DEF_SETS,
    parameter int WAYS    = DEF_WAYS,
    parameter int SLOTS   = DEF_SLOTS,
    parameter int PAY_W   = DEF_PAY_W,
    parameter int LEN_W   = DEF_LEN_W,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - CHUNK_B - SET_W,
    localparam int WAY_W  = $clog2(WAYS + 1),
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   start_en,
    input  logic [TAG_W-1:0]       start_tag,
    input  logic                   wr_en,
    input  logic [SET_W-1:0]       wr_set,
    input  logic [WAY_W-1:0]       wr_way,
    input  logic [SLOT_W-1:0]      wr_slot,
    input  logic [PAY_W-1:0]       wr_pay,
    input  logic [LEN_W-1:0]       wr_len,
    input  logic                   commit_en,
    input  logic [WAY_W-1:0]       commit_nw,
    input  logic                   ovf_en,
    output logic                   probe_unc_hit,
    input  logic [SET_W-1:0]       lk_set,
    input  logic [TAG_W-1:0]       lk_tag,
    output logic                   lk_hit,
    output logic [WAY_W-1:0]       lk_nw,
    input  logic [SET_W-1:0]       rd_set,
    input  logic [WAY_W-1:0]       rd_way,
    output logic [SLOT_W-1:0]      rd_cnt,
    output logic [SLOTS*PAY_W-1:0] rd_pay,
    output logic [SLOTS*LEN_W-1:0] rd_len
);
    logic [SETS-1:0]   vld_q, unc_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [WAY_W-1:0]  nw_q  [SETS];
    logic [SLOT_W-1:0] cnt_q [SETS][WAYS];
    logic [PAY_W-1:0]  pay_q [SETS][WAYS][SLOTS];
    logic [LEN_W-1:0]  len_q [SETS][WAYS][SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            unc_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
            unc_q <= '0;
        end else begin
            if (start_en) begin
                vld_q[wr_set] <= 1'b0;
                unc_q[wr_set] <= 1'b0;
            end
            if (commit_en) vld_q[wr_set] <= 1'b1;
            if (ovf_en) begin
                vld_q[wr_set] <= 1'b0;
                unc_q[wr_set] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (start_en) begin
            tag_q[wr_set] <= start_tag;
            for (int w = 0; w < WAYS; w++) cnt_q[wr_set][w] <= '0;
        end
        if (wr_en) begin
            cnt_q[wr_set][wr_way]          <= wr_slot + 1'b1;
            pay_q[wr_set][wr_way][wr_slot] <= wr_pay;
            len_q[wr_set][wr_way][wr_slot] <= wr_len;
        end
        if (commit_en) nw_q[wr_set] <= commit_nw;
    end

    assign probe_unc_hit = unc_q[wr_set] && (tag_q[wr_set] == start_tag);
    assign lk_hit        = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign lk_nw         = nw_q[lk_set];
    assign rd_cnt        = cnt_q[rd_set][rd_way];

    for (genvar s = 0; s < SLOTS; s++) begin : g_rd
        assign rd_pay[s*PAY_W +: PAY_W] = pay_q[rd_set][rd_way][s];
        assign rd_len[s*LEN_W +: LEN_W] = len_q[rd_set][rd_way][s];
    end

    // R3
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_slot < SLOT_W'(SLOTS)) && (wr_way < WAY_W'(WAYS)));
    // R5
    ovf_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_en && !flush) |=> unc_q[$past(wr_set)] && !vld_q[$past(wr_set)]);
endmodule

// File: rtl/uwc_lookup.sv
module uwc_lookup
    import uwc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CHUNK_B = DEF_CHUNK_B,
    parameter int SETS    = DEF_SETS,
    parameter int WAYS    = DEF_WAYS,
    parameter int SLOTS   = DEF_SLOTS,
    parameter int PAY_W   = DEF_PAY_W,
    parameter int LEN_W   = DEF_LEN_W,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - CHUNK_B - SET_W,
    localparam int WAY_W  = $clog2(WAYS + 1),
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   lk_valid,
    input  logic [ADDR_W-1:0]      lk_addr,
    output logic [SET_W-1:0]       l_set,
    output logic [TAG_W-1:0]       l_tag,
    input  logic                   l_hit,
    input  logic [WAY_W-1:0]       l_nw,
    output logic [SET_W-1:0]       rd_set,
    output logic [WAY_W-1:0]       rd_way,
    input  logic [SLOT_W-1:0]      rd_cnt,
    input  logic [SLOTS*PAY_W-1:0] rd_pay,
    input  logic [SLOTS*LEN_W-1:0] rd_len,
    output logic                   lk_ready,
    output logic                   hit_o,
    output logic                   miss_o,
    output logic                   switch_o,
    output logic [CHUNK_B:0]       fetch_bytes,
    output logic                   out_way_valid,
    output logic                   out_last_way,
    output logic [SLOTS-1:0]       out_slot_vld,
    output logic [SLOTS*PAY_W-1:0] out_payload,
    output logic [SLOTS*LEN_W-1:0] out_len
);
    localparam logic [CHUNK_B:0] HIT_B = {1'b1, {CHUNK_B{1'b0}}};
    localparam logic [CHUNK_B:0] LEG_B = {2'b01, {(CHUNK_B-1){1'b0}}};

    look_st_e         state_q, state_d;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q, nw_q;
    logic             hit_q, miss_q, sw_q, seen_q, prev_hit_q, wide_q;
    logic             accept, at_last;

    assign l_set   = lk_addr[CHUNK_B +: SET_W];
    assign l_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign accept  = (state_q == LK_IDLE) && lk_valid && !flush;
    assign at_last = (way_q == nw_q - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE:   if (accept && l_hit) state_d = LK_STREAM;
            LK_STREAM: if (at_last)         state_d = LK_IDLE;
            default:                        state_d = LK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LK_IDLE;
            set_q      <= '0;
            way_q      <= '0;
            nw_q       <= '0;
            hit_q      <= 1'b0;
            miss_q     <= 1'b0;
            sw_q       <= 1'b0;
            seen_q     <= 1'b0;
            prev_hit_q <= 1'b0;
            wide_q     <= 1'b0;
        end else if (flush) begin
            state_q    <= LK_IDLE;
            hit_q      <= 1'b0;
            miss_q     <= 1'b0;
            sw_q       <= 1'b0;
            seen_q     <= 1'b0;
            wide_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            hit_q   <= accept && l_hit;
            miss_q  <= accept && !l_hit;
            sw_q    <= accept && seen_q && (prev_hit_q != l_hit);
            if (accept) begin
                seen_q     <= 1'b1;
                prev_hit_q <= l_hit;
                wide_q     <= l_hit;
                set_q      <= l_set;
                nw_q       <= l_nw;
                way_q      <= '0;
            end else if (state_q == LK_STREAM && !at_last) begin
                way_q <= way_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        lk_ready      = (state_q == LK_IDLE);
        out_way_valid = (state_q == LK_STREAM);
        out_last_way  = out_way_valid && at_last;
        hit_o         = hit_q;
        miss_o        = miss_q;
        switch_o      = sw_q;
        fetch_bytes   = wide_q ? HIT_B : LEG_B;
        rd_set        = set_q;
        rd_way        = way_q;
        out_payload   = out_way_valid ? rd_pay : '0;
        out_len       = out_way_valid ? rd_len : '0;
        for (int s = 0; s < SLOTS; s++)
            out_slot_vld[s] = out_way_valid && (SLOT_W'(s) < rd_cnt);
    end

    // R10
    sw_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |-> (hit_o || miss_o));
    // R8
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));
    // R7
    hit_starts_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> out_way_valid && (way_q == '0) && !lk_ready);
    // R7
    stream_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_way_valid |-> out_slot_vld[0]);
endmodule

// File: rtl/uop_window_cache.sv
module uop_window_cache
    import uwc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CHUNK_B = DEF_CHUNK_B,
    parameter int SETS    = DEF_SETS,
    parameter int WAYS    = DEF_WAYS,
    parameter int SLOTS   = DEF_SLOTS,
    parameter int PAY_W   = DEF_PAY_W,
    parameter int LEN_W   = DEF_LEN_W,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - CHUNK_B - SET_W,
    localparam int WAY_W  = $clog2(WAYS + 1),
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   fill_valid,
    input  logic [ADDR_W-1:0]      fill_addr,
    input  logic [PAY_W-1:0]       fill_payload,
    input  logic [LEN_W-1:0]       fill_len,
    input  logic                   fill_jump,
    input  logic                   fill_last,
    input  logic                   lk_valid,
    input  logic [ADDR_W-1:0]      lk_addr,
    output logic                   lk_ready,
    output logic                   hit_o,
    output logic                   miss_o,
    output logic                   switch_o,
    output logic [CHUNK_B:0]       fetch_bytes,
    output logic                   out_way_valid,
    output logic                   out_last_way,
    output logic [SLOTS-1:0]       out_slot_vld,
    output logic [SLOTS*PAY_W-1:0] out_payload,
    output logic [SLOTS*LEN_W-1:0] out_len
);
    logic [TAG_W-1:0]       f_tag, l_tag;
    logic                   start_en, wr_en, commit_en, ovf_en, probe_unc_hit, l_hit;
    logic [SET_W-1:0]       wr_set, l_set, rd_set;
    logic [WAY_W-1:0]       wr_way, commit_nw, l_nw, rd_way;
    logic [SLOT_W-1:0]      wr_slot, rd_cnt;
    logic [SLOTS*PAY_W-1:0] rd_pay;
    logic [SLOTS*LEN_W-1:0] rd_len;

    uwc_fill_ctl #(.ADDR_W(ADDR_W), .CHUNK_B(CHUNK_B), .SETS(SETS), .WAYS(WAYS),
                   .SLOTS(SLOTS)) fill_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_jump(fill_jump), .fill_last(fill_last),
        .probe_unc_hit(probe_unc_hit), .f_tag(f_tag), .start_en(start_en),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_slot(wr_slot),
        .commit_en(commit_en), .commit_nw(commit_nw), .ovf_en(ovf_en));

    uwc_store #(.ADDR_W(ADDR_W), .CHUNK_B(CHUNK_B), .SETS(SETS), .WAYS(WAYS),
                .SLOTS(SLOTS), .PAY_W(PAY_W), .LEN_W(LEN_W)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start_en(start_en),
        .start_tag(f_tag), .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way),
        .wr_slot(wr_slot), .wr_pay(fill_payload), .wr_len(fill_len),
        .commit_en(commit_en), .commit_nw(commit_nw), .ovf_en(ovf_en),
        .probe_unc_hit(probe_unc_hit), .lk_set(l_set), .lk_tag(l_tag),
        .lk_hit(l_hit), .lk_nw(l_nw), .rd_set(rd_set), .rd_way(rd_way),
        .rd_cnt(rd_cnt), .rd_pay(rd_pay), .rd_len(rd_len));

    uwc_lookup #(.ADDR_W(ADDR_W), .CHUNK_B(CHUNK_B), .SETS(SETS), .WAYS(WAYS),
                 .SLOTS(SLOTS), .PAY_W(PAY_W), .LEN_W(LEN_W)) look_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .l_set(l_set), .l_tag(l_tag), .l_hit(l_hit),
        .l_nw(l_nw), .rd_set(rd_set), .rd_way(rd_way), .rd_cnt(rd_cnt),
        .rd_pay(rd_pay), .rd_len(rd_len), .lk_ready(lk_ready), .hit_o(hit_o),
        .miss_o(miss_o), .switch_o(switch_o), .fetch_bytes(fetch_bytes),
        .out_way_valid(out_way_valid), .out_last_way(out_last_way),
        .out_slot_vld(out_slot_vld), .out_payload(out_payload), .out_len(out_len));
endmodule

// File: tb/uop_window_cache_tb_top.sv
module uop_window_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [15:0] fill_payload = '0;
    logic [3:0]  fill_len = '0;
    logic        fill_jump = 1'b0;
    logic        fill_last = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, hit_o, miss_o, switch_o, out_way_valid, out_last_way;
    logic [5:0]  fetch_bytes;
    logic [5:0]  out_slot_vld;
    logic [95:0] out_payload;
    logic [23:0] out_len;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  prev_known = 1'b0;
    bit  prev_hit_m = 1'b0;

    always #4 clk = ~clk;

    uop_window_cache dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_payload(fill_payload), .fill_len(fill_len),
        .fill_jump(fill_jump), .fill_last(fill_last), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_ready(lk_ready), .hit_o(hit_o), .miss_o(miss_o),
        .switch_o(switch_o), .fetch_bytes(fetch_bytes), .out_way_valid(out_way_valid),
        .out_last_way(out_last_way), .out_slot_vld(out_slot_vld),
        .out_payload(out_payload), .out_len(out_len));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_seq(input logic [31:0] base, input int n,
                            input logic [31:0] jmask, input int pbase);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_valid   = 1'b1;
            fill_addr    = base + 32'(i % 32);
            fill_payload = 16'(pbase + i);
            fill_len     = 4'((i % 15) + 1);
            fill_jump    = jmask[i];
            fill_last    = (i == n - 1);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        fill_jump  = 1'b0;
        fill_last  = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input bit exp_hit, input int c0,
                        input int c1, input int c2, input int pbase, input string req);
        int  cnts[3];
        int  expn;
        int  idx;
        int  errs;
        bit  exp_sw;
        cnts[0] = c0; cnts[1] = c1; cnts[2] = c2;
        expn = (c0 != 0 ? 1 : 0) + (c1 != 0 ? 1 : 0) + (c2 != 0 ? 1 : 0);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        exp_sw = prev_known && (prev_hit_m != exp_hit);
        chk(hit_o == exp_hit, req, "hit_o", int'(hit_o), int'(exp_hit));
        chk(miss_o == !exp_hit, exp_hit ? req : "R8", "miss_o", int'(miss_o), int'(!exp_hit));
        chk(switch_o == exp_sw, "R10", "switch_o", int'(switch_o), int'(exp_sw));
        chk(fetch_bytes == (exp_hit ? 6'd32 : 6'd16), "R11", "fetch_bytes",
            int'(fetch_bytes), exp_hit ? 32 : 16);
        prev_known = 1'b1;
        prev_hit_m = exp_hit;
        if (exp_hit) begin
            idx  = 0;
            errs = 0;
            for (int w = 0; w < expn; w++) begin
                chk(out_way_valid && out_slot_vld == 6'((1 << cnts[w]) - 1), req,
                    "way slot valid", int'(out_slot_vld), (1 << cnts[w]) - 1);
                chk(out_last_way == (w == expn - 1) && !lk_ready, "R7",
                    "last/ready", int'({out_last_way, lk_ready}), (w == expn - 1) ? 2 : 0);
                for (int s = 0; s < cnts[w]; s++) begin
                    if (out_payload[s*16 +: 16] != 16'(pbase + idx)) errs++;
                    if (out_len[s*4 +: 4] != 4'((idx % 15) + 1)) errs++;
                    idx++;
                end
                @(negedge clk);
            end
            chk(errs == 0, "R7", "slot payload/length mismatches", errs, 0);
        end
        chk(!out_way_valid && lk_ready, exp_hit ? "R7" : "R8", "stream ended",
            int'({out_way_valid, lk_ready}), 1);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        prev_known = 1'b0;
    endtask

    task automatic t_reset();
        chk(!hit_o && !miss_o && !switch_o && !out_way_valid, "R1", "reset pulses",
            int'({hit_o, miss_o, switch_o, out_way_valid}), 0);
        chk(lk_ready && fetch_bytes == 6'd16, "R1", "reset ready/bytes",
            int'(fetch_bytes), 16);
        look(32'h0000_1040, 1'b0, 0, 0, 0, 0, "R1");
    endtask

    task automatic t_pack();
        fill_seq(32'h0000_1040, 8, 32'h0, 100);
        look(32'h0000_1053, 1'b1, 6, 2, 0, 100, "R3");
        look(32'h0000_105F, 1'b1, 6, 2, 0, 100, "R2");
        look(32'h0000_1060, 1'b0, 0, 0, 0, 0, "R2");
    endtask

    task automatic t_jump();
        fill_seq(32'h0000_1060, 5, 32'h2, 200);
        look(32'h0000_1060, 1'b1, 2, 3, 0, 200, "R4");
        fill_seq(32'h0000_1100, 7, 32'h20, 250);
        look(32'h0000_1100, 1'b1, 6, 1, 0, 250, "R4");
    endtask

    task automatic t_limit();
        fill_seq(32'h0000_1080, 3, 32'h7, 300);
        look(32'h0000_1080, 1'b1, 1, 1, 1, 300, "R5");
        fill_seq(32'h0000_10C0, 18, 32'h0, 400);
        look(32'h0000_10C0, 1'b1, 6, 6, 6, 400, "R5");
        fill_seq(32'h0000_10A0, 4, 32'hF, 500);
        look(32'h0000_10A0, 1'b0, 0, 0, 0, 0, "R5");
        fill_seq(32'h0000_10E0, 19, 32'h0, 600);
        look(32'h0000_10E0, 1'b0, 0, 0, 0, 0, "R5");
        fill_seq(32'h0000_10A0, 1, 32'h0, 650);
        look(32'h0000_10A0, 1'b0, 0, 0, 0, 0, "R5");
        look(32'h0000_5040, 1'b0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_evict();
        fill_seq(32'h0000_3040, 2, 32'h0, 700);
        look(32'h0000_1040, 1'b0, 0, 0, 0, 0, "R9");
        look(32'h0000_3040, 1'b1, 2, 0, 0, 700, "R9");
    endtask

    task automatic t_flush();
        do_flush();
        look(32'h0000_3040, 1'b0, 0, 0, 0, 0, "R6");
        fill_seq(32'h0000_10A0, 1, 32'h0, 800);
        look(32'h0000_10A0, 1'b1, 1, 0, 0, 800, "R6");
    endtask

    task automatic t_switch();
        look(32'h0000_3040, 1'b0, 0, 0, 0, 0, "R10");
        look(32'h9999_0000, 1'b0, 0, 0, 0, 0, "R10");
        look(32'h0000_10A4, 1'b1, 1, 0, 0, 800, "R10");
        look(32'h0000_10A0, 1'b1, 1, 0, 0, 800, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            chk(!hit_o && !miss_o && !out_way_valid && lk_ready, "R1", "in reset",
                int'({hit_o, miss_o, out_way_valid, lk_ready}), 1);
        end
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_jump();
        t_limit();
        t_evict();
        t_flush();
        t_switch();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule